// File: doc/BRIEF.md
# Interrupt Distributor Register Front End

This block is the register side of an interrupt distributor. A single 32-bit memory-mapped port reads and writes a set of word-sized registers. The port has a request valid, a read/write flag, a word address and an access size in bytes. The block holds a global forwarding switch and, for each interrupt, an enable bit, a pending bit and an active bit. Each of these bitmaps is changed through a pair of aliased windows. The "raise" alias sets every bit written as one. The "drop" alias clears every bit written as one. A zero in either alias leaves the bit alone, so several agents can change different interrupts without a read-modify-write.

The block also holds a plain 8-bit-per-interrupt priority array and a 2-bit-per-interrupt trigger configuration array. It has a read-only capability word that describes how many processors and interrupts the distributor serves, and a read-only identity word. A group window and every unassigned offset read as zero and ignore writes. An access wider than one word is refused with an abort and changes nothing.

The downstream arbitration logic takes the state straight from the output ports. It reads a one-cycle update strobe as a hint to re-evaluate after a write has changed any of that state.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the global switch, every enable, pending and active bit, the response valid, the abort flag and the update strobe are all 0.
- R2: The control word sits at byte offset 0x000. A write stores only data bit 0 as the global switch, which drives `glb_en`. A read returns that bit in bit 0 with all other bits 0.
- R3: The capability word sits at offset 0x004 and reads ((NUM_CPU-1) << 5) | (NUM_IRQ/32 - 1), which is 0x61 with the defaults. Writes to it change nothing.
- R4: The identity word sits at offset 0x008 and reads PRODUCT_CODE in bits [31:24], zero in bits [23:12] and IMPL_CODE in bits [11:0], which is 0xA70002C5 with the defaults. Writes to it change nothing.
- R5: Each bitmap has a raise alias. The enable raise window starts at 0x200, the pending raise window at 0x300 and the active raise window at 0x400. Word w, bit n maps to interrupt 32w+n. Writing 1 sets the bit and writing 0 leaves it unchanged. Reading either alias returns the current bitmap word.
- R6: Each bitmap has a drop alias at the raise base plus 0x080 (0x280, 0x380 and 0x480). Writing 1 clears the bit and writing 0 leaves it unchanged.
- R7: The enable, pending and active bitmaps are independent. A write to one bitmap's windows leaves the other two unchanged.
- R8: The group window at 0x100, bitmap words at or beyond NUM_IRQ/32, and every offset outside a defined window read as zero and ignore writes.
- R9: The priority window at 0x600 holds one byte per interrupt. Byte k of word w belongs to interrupt 4w+k. Every bit is stored as written and reads back unchanged.
- R10: The configuration window at 0x500 holds two bits per interrupt. Bits [2k+1:2k] of word w belong to interrupt 16w+k. The window spans NUM_IRQ/16 words and stores and returns full words.
- R11: A request with `req_size` greater than 4 is answered with `resp_abort` = 1 and read data 0, and it changes no state.
- R12: `upd_pulse` is high for exactly the response cycle of a write that changed the global switch or any enable, pending or active bit, and is low otherwise. Priority and configuration writes do not raise it.
- R13: Every request is answered by `resp_valid` = 1 in the cycle after it is presented, and `resp_valid` is 0 in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | 32 | Read data, 0 for writes and aborts |
| resp_abort | output | 1 | Request refused because it was wider than a word |
| glb_en | output | 1 | Global forwarding switch |
| irq_en | output | NUM_IRQ | Per-interrupt enable bits |
| irq_pend | output | NUM_IRQ | Per-interrupt pending bits |
| irq_act | output | NUM_IRQ | Per-interrupt active bits |
| upd_pulse | output | 1 | One-cycle strobe after a state-changing write |

## Verification
Every result of a request is registered at the clock edge that samples the request. These results are the response valid, read data, abort flag, update strobe and the new state on the bitmap and switch ports. All of them are therefore due exactly one cycle after the request. The bench presents each request on a falling edge, lets one rising edge pass, and samples every output on the next falling edge. That is the single cycle in which the strobe and response are visible. An idle cycle is then sampled to confirm that the response and strobe have dropped.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

   // Register windows seen by the decoder.
   typedef enum logic [3:0] {
      WIN_NONE,
      WIN_CTRL,
      WIN_TYPE,
      WIN_IDENT,
      WIN_EN_SET,
      WIN_EN_CLR,
      WIN_PD_SET,
      WIN_PD_CLR,
      WIN_AC_SET,
      WIN_AC_CLR,
      WIN_CFG,
      WIN_PRIO
   } win_e;

   // Byte offsets of the windows.
   localparam int unsigned OFS_CTRL   = 32'h000;
   localparam int unsigned OFS_TYPE   = 32'h004;
   localparam int unsigned OFS_IDENT  = 32'h008;
   localparam int unsigned OFS_GROUP  = 32'h100;
   localparam int unsigned OFS_EN_SET = 32'h200;
   localparam int unsigned OFS_PD_SET = 32'h300;
   localparam int unsigned OFS_AC_SET = 32'h400;
   localparam int unsigned OFS_CFG    = 32'h500;
   localparam int unsigned OFS_PRIO   = 32'h600;
   // The drop alias of each bitmap lies this far above its raise alias.
   localparam int unsigned OFS_CLR_DELTA = 32'h080;

   // Widest access that is decoded, in bytes.
   localparam int unsigned MAX_ACCESS_BYTES = 4;
   // Number of bitmaps: enable, pending, active.
   localparam int unsigned NUM_BITMAPS = 3;

endpackage

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned IDX_W   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned BM_BYTES   = NUM_IRQ / 8;
   localparam int unsigned CFG_BYTES  = NUM_IRQ / 4;
   localparam int unsigned PRIO_BYTES = NUM_IRQ;

   function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                   input int unsigned base,
                                   input int unsigned len);
      return (32'(a) >= base) && (32'(a) < base + len);
   endfunction

   function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a,
                                                input int unsigned base);
      return IDX_W'((32'(a) - base) >> 2);
   endfunction

   logic [ADDR_W-1:0] wa;

   always_comb begin
      wa  = {addr[ADDR_W-1:2], 2'b00};
      win = WIN_NONE;
      idx = '0;
      // The group window and all unassigned space fall through to WIN_NONE.
      if (32'(wa) == OFS_CTRL) begin
         win = WIN_CTRL;
      end else if (32'(wa) == OFS_TYPE) begin
         win = WIN_TYPE;
      end else if (32'(wa) == OFS_IDENT) begin
         win = WIN_IDENT;
      end else if (in_win(wa, OFS_EN_SET, BM_BYTES)) begin
         win = WIN_EN_SET; idx = word_of(wa, OFS_EN_SET);
      end else if (in_win(wa, OFS_EN_SET + OFS_CLR_DELTA, BM_BYTES)) begin
         win = WIN_EN_CLR; idx = word_of(wa, OFS_EN_SET + OFS_CLR_DELTA);
      end else if (in_win(wa, OFS_PD_SET, BM_BYTES)) begin
         win = WIN_PD_SET; idx = word_of(wa, OFS_PD_SET);
      end else if (in_win(wa, OFS_PD_SET + OFS_CLR_DELTA, BM_BYTES)) begin
         win = WIN_PD_CLR; idx = word_of(wa, OFS_PD_SET + OFS_CLR_DELTA);
      end else if (in_win(wa, OFS_AC_SET, BM_BYTES)) begin
         win = WIN_AC_SET; idx = word_of(wa, OFS_AC_SET);
      end else if (in_win(wa, OFS_AC_SET + OFS_CLR_DELTA, BM_BYTES)) begin
         win = WIN_AC_CLR; idx = word_of(wa, OFS_AC_SET + OFS_CLR_DELTA);
      end else if (in_win(wa, OFS_CFG, CFG_BYTES)) begin
         win = WIN_CFG; idx = word_of(wa, OFS_CFG);
      end else if (in_win(wa, OFS_PRIO, PRIO_BYTES)) begin
         win = WIN_PRIO; idx = word_of(wa, OFS_PRIO);
      end
   end

endmodule

// File: rtl/irq_dist_bitmap.sv
module irq_dist_bitmap #(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [31:0]        wdata,
   output logic [NUM_IRQ-1:0] bits,
   output logic               changed
);

   localparam int unsigned WORDS = NUM_IRQ / 32;

   logic [NUM_IRQ-1:0] nxt;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic        hit;
      logic [31:0] cur;
      logic [31:0] upd;
      assign hit = (idx == IDX_W'(w));
      assign cur = bits[w*32 +: 32];
      always_comb begin
         upd = cur;
         if (hit && set_en) begin
            upd = cur | wdata;
         end else if (hit && clr_en) begin
            upd = cur & ~wdata;
         end
      end
      assign nxt[w*32 +: 32] = upd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits <= '0;
      end else begin
         bits <= nxt;
      end
   end

   assign changed = (nxt != bits);

endmodule

// File: rtl/irq_dist_wordstore.sv
module irq_dist_wordstore #(
   parameter int unsigned NUM_WORDS = 16,
   parameter int unsigned IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata
);

   localparam int unsigned LW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   logic [31:0] mem [NUM_WORDS];
   logic        in_range;
   logic [LW-1:0] sel;

   assign in_range = (32'(idx) < NUM_WORDS);
   assign sel      = idx[LW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            mem[i] <= '0;
         end
      end else if (we && in_range) begin
         mem[sel] <= wdata;
      end
   end

   assign rdata = in_range ? mem[sel] : '0;

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IRQ      = 64,
   parameter int unsigned NUM_CPU      = 4,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [7:0]  PRODUCT_CODE = 8'hA7,
   parameter logic [11:0] IMPL_CODE    = 12'h2C5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [3:0]         req_size,
   input  logic [31:0]        req_wdata,
   output logic               resp_valid,
   output logic [31:0]        resp_rdata,
   output logic               resp_abort,
   output logic               glb_en,
   output logic [NUM_IRQ-1:0] irq_en,
   output logic [NUM_IRQ-1:0] irq_pend,
   output logic [NUM_IRQ-1:0] irq_act,
   output logic               upd_pulse
);

   localparam int unsigned PRIO_WORDS = NUM_IRQ / 4;
   localparam int unsigned CFG_WORDS  = NUM_IRQ / 16;
   localparam int unsigned IDX_W      = $clog2(PRIO_WORDS);
   localparam logic [31:0] TYPE_WORD  = 32'((NUM_CPU - 1) << 5) | 32'(NUM_IRQ / 32 - 1);
   localparam logic [31:0] IDENT_WORD = {PRODUCT_CODE, 12'h000, IMPL_CODE};

   // Elaboration-time parameter checks.
   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 32 || NUM_IRQ > 1024) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must lie between 1 and 8");
   end
   if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 12 and 32");
   end

   // Request qualification.
   logic oversize, go, wr;
   assign oversize = (req_size > 4'(MAX_ACCESS_BYTES));
   assign go       = req_valid && !oversize;
   assign wr       = go && req_write;

   win_e             win;
   logic [IDX_W-1:0] idx;

   irq_dist_decode #(
      .NUM_IRQ (NUM_IRQ),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W)
   ) decode_i (
      .addr (req_addr),
      .win  (win),
      .idx  (idx)
   );

   // Bitmaps: 0 = enable, 1 = pending, 2 = active.
   logic [NUM_BITMAPS-1:0] set_hit, clr_hit, bm_changed;
   logic [NUM_IRQ-1:0]     bm_bits [NUM_BITMAPS];
   logic [31:0]            bm_word [NUM_BITMAPS];

   always_comb begin
      set_hit = '0;
      clr_hit = '0;
      if (wr) begin
         case (win)
            WIN_EN_SET: set_hit[0] = 1'b1;
            WIN_EN_CLR: clr_hit[0] = 1'b1;
            WIN_PD_SET: set_hit[1] = 1'b1;
            WIN_PD_CLR: clr_hit[1] = 1'b1;
            WIN_AC_SET: set_hit[2] = 1'b1;
            WIN_AC_CLR: clr_hit[2] = 1'b1;
            default:    ;
         endcase
      end
   end

   for (genvar k = 0; k < NUM_BITMAPS; k++) begin : g_bm
      irq_dist_bitmap #(
         .NUM_IRQ (NUM_IRQ),
         .IDX_W   (IDX_W)
      ) bitmap_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_en  (set_hit[k]),
         .clr_en  (clr_hit[k]),
         .idx     (idx),
         .wdata   (req_wdata),
         .bits    (bm_bits[k]),
         .changed (bm_changed[k])
      );
      assign bm_word[k] = bm_bits[k][32*int'(idx) +: 32];
   end

   assign irq_en   = bm_bits[0];
   assign irq_pend = bm_bits[1];
   assign irq_act  = bm_bits[2];

   // Global switch.
   logic glb_q, glb_change;
   assign glb_change = wr && (win == WIN_CTRL) && (req_wdata[0] != glb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= 1'b0;
      end else if (wr && (win == WIN_CTRL)) begin
         glb_q <= req_wdata[0];
      end
   end
   assign glb_en = glb_q;

   // Priority and configuration arrays.
   logic [31:0] prio_rd, cfg_rd;

   irq_dist_wordstore #(
      .NUM_WORDS (PRIO_WORDS),
      .IDX_W     (IDX_W)
   ) prio_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && (win == WIN_PRIO)),
      .idx   (idx),
      .wdata (req_wdata),
      .rdata (prio_rd)
   );

   irq_dist_wordstore #(
      .NUM_WORDS (CFG_WORDS),
      .IDX_W     (IDX_W)
   ) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && (win == WIN_CFG)),
      .idx   (idx),
      .wdata (req_wdata),
      .rdata (cfg_rd)
   );

   // Read mux.
   logic [31:0] rd;
   always_comb begin
      case (win)
         WIN_CTRL:               rd = {31'b0, glb_q};
         WIN_TYPE:               rd = TYPE_WORD;
         WIN_IDENT:              rd = IDENT_WORD;
         WIN_EN_SET, WIN_EN_CLR: rd = bm_word[0];
         WIN_PD_SET, WIN_PD_CLR: rd = bm_word[1];
         WIN_AC_SET, WIN_AC_CLR: rd = bm_word[2];
         WIN_CFG:                rd = cfg_rd;
         WIN_PRIO:               rd = prio_rd;
         default:                rd = '0;
      endcase
   end

   // Response stage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_abort <= 1'b0;
         resp_rdata <= '0;
         upd_pulse  <= 1'b0;
      end else begin
         resp_valid <= req_valid;
         resp_abort <= req_valid && oversize;
         resp_rdata <= (go && !req_write) ? rd : '0;
         upd_pulse  <= wr && ((|bm_changed) || glb_change);
      end
   end

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk
   import irq_dist_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned ADDR_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [3:0]         req_size,
   input logic               resp_valid,
   input logic [31:0]        resp_rdata,
   input logic               resp_abort,
   input logic               glb_en,
   input logic [NUM_IRQ-1:0] irq_en,
   input logic [NUM_IRQ-1:0] irq_pend,
   input logic [NUM_IRQ-1:0] irq_act,
   input logic               upd_pulse
);

   localparam int unsigned BM_BYTES = NUM_IRQ / 8;

   logic wr_ok, en_set_wr, en_clr_wr;
   assign wr_ok     = req_valid && req_write && (req_size <= 4'(MAX_ACCESS_BYTES));
   assign en_set_wr = wr_ok && (32'(req_addr) >= OFS_EN_SET)
                      && (32'(req_addr) < OFS_EN_SET + BM_BYTES);
   assign en_clr_wr = wr_ok && (32'(req_addr) >= OFS_EN_SET + OFS_CLR_DELTA)
                      && (32'(req_addr) < OFS_EN_SET + OFS_CLR_DELTA + BM_BYTES);

   AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid); // R13
   AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(req_valid)); // R13
   AST_ABORT_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      resp_abort |-> resp_valid); // R11
   AST_ABORT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size > 4'(MAX_ACCESS_BYTES)) |=>
         (resp_abort && resp_rdata == 32'h0 && $stable(irq_en) && $stable(irq_pend)
          && $stable(irq_act) && $stable(glb_en))); // R11
   AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=>
         ($stable(irq_en) && $stable(irq_pend) && $stable(irq_act) && $stable(glb_en))); // R12
   AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> $past(req_valid && req_write)); // R12
   AST_CHANGE_RAISES_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_en != $past(irq_en)) || (irq_pend != $past(irq_pend))
       || (irq_act != $past(irq_act)) || (glb_en != $past(glb_en))) |-> upd_pulse); // R12
   AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_wr |=> (($past(irq_en) & ~irq_en) == '0)); // R5
   AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_wr |=> ((irq_en & ~$past(irq_en)) == '0)); // R6

endmodule

bind irq_dist_regs irq_dist_regs_chk #(
   .NUM_IRQ (NUM_IRQ),
   .ADDR_W  (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_size   (req_size),
   .resp_valid (resp_valid),
   .resp_rdata (resp_rdata),
   .resp_abort (resp_abort),
   .glb_en     (glb_en),
   .irq_en     (irq_en),
   .irq_pend   (irq_pend),
   .irq_act    (irq_act),
   .upd_pulse  (upd_pulse)
);

// File: tb/irq_dist_regs_tb_top.sv
`timescale 1ns/1ps
module irq_dist_regs_tb_top;

   localparam int unsigned NUM_IRQ = 64;
   localparam int unsigned ADDR_W  = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic               req_write = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [3:0]         req_size = 4'd4;
   logic [31:0]        req_wdata = '0;
   logic               resp_valid;
   logic [31:0]        resp_rdata;
   logic               resp_abort;
   logic               glb_en;
   logic [NUM_IRQ-1:0] irq_en, irq_pend, irq_act;
   logic               upd_pulse;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   irq_dist_regs dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .resp_valid (resp_valid),
      .resp_rdata (resp_rdata),
      .resp_abort (resp_abort),
      .glb_en     (glb_en),
      .irq_en     (irq_en),
      .irq_pend   (irq_pend),
      .irq_act    (irq_act),
      .upd_pulse  (upd_pulse)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Present one request at a falling edge and sample its response one cycle later.
   logic [31:0] r_data;
   logic        r_abort, r_upd, r_valid;

   task automatic acc(input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [3:0] sz, input logic [31:0] wd);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_size  = sz;
      req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      r_valid   = resp_valid;
      r_data    = resp_rdata;
      r_abort   = resp_abort;
      r_upd     = upd_pulse;
   endtask

   task automatic wr32(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      acc(1'b1, a, 4'd4, d);
   endtask

   task automatic rd32(input logic [ADDR_W-1:0] a);
      acc(1'b0, a, 4'd4, 32'h0);
   endtask

   task automatic t_reset;
      chk("R1", "glb_en", 64'(glb_en), 64'h0);
      chk("R1", "irq_en", 64'(irq_en), 64'h0);
      chk("R1", "irq_pend", 64'(irq_pend), 64'h0);
      chk("R1", "irq_act", 64'(irq_act), 64'h0);
      chk("R1", "resp/abort/upd", 64'({resp_valid, resp_abort, upd_pulse}), 64'h0);
   endtask

   task automatic t_timing;
      rd32(12'h000);
      chk("R13", "resp_valid after request", 64'(r_valid), 64'h1);
      @(negedge clk);
      chk("R13", "resp_valid idle", 64'(resp_valid), 64'h0);
   endtask

   task automatic t_ctrl;
      wr32(12'h000, 32'hFFFF_FFFF);
      chk("R12", "upd on switch change", 64'(r_upd), 64'h1);
      chk("R2", "glb_en set", 64'(glb_en), 64'h1);
      @(negedge clk);
      chk("R12", "upd one cycle", 64'(upd_pulse), 64'h0);
      rd32(12'h000);
      chk("R2", "ctrl readback", 64'(r_data), 64'h1);
      wr32(12'h000, 32'h0000_0001);
      chk("R12", "upd on unchanged write", 64'(r_upd), 64'h0);
      wr32(12'h000, 32'h0000_0000);
      chk("R2", "glb_en cleared", 64'(glb_en), 64'h0);
   endtask

   task automatic t_type_ident;
      rd32(12'h004);
      chk("R3", "type word", 64'(r_data), 64'h61);
      wr32(12'h004, 32'h0);
      rd32(12'h004);
      chk("R3", "type after write", 64'(r_data), 64'h61);
      rd32(12'h008);
      chk("R4", "ident word", 64'(r_data), 64'hA700_02C5);
      wr32(12'h008, 32'hFFFF_FFFF);
      rd32(12'h008);
      chk("R4", "ident after write", 64'(r_data), 64'hA700_02C5);
   endtask

   task automatic t_enable;
      wr32(12'h200, 32'h0000_00F0);
      chk("R5", "set low word", 64'(irq_en), 64'h0000_0000_0000_00F0);
      chk("R12", "upd on set", 64'(r_upd), 64'h1);
      wr32(12'h204, 32'h8000_0001);
      chk("R5", "set high word", 64'(irq_en), 64'h8000_0001_0000_00F0);
      wr32(12'h200, 32'h0000_0003);
      chk("R5", "zeros keep bits", 64'(irq_en), 64'h8000_0001_0000_00F3);
      rd32(12'h280);
      chk("R5", "read via drop alias", 64'(r_data), 64'hF3);
      wr32(12'h280, 32'h0000_0030);
      chk("R6", "drop clears ones", 64'(irq_en), 64'h8000_0001_0000_00C3);
      wr32(12'h284, 32'h0000_0000);
      chk("R6", "drop zeros keep", 64'(irq_en), 64'h8000_0001_0000_00C3);
      chk("R12", "no upd without change", 64'(r_upd), 64'h0);
   endtask

   task automatic t_pend_act;
      wr32(12'h300, 32'hAAAA_5555);
      wr32(12'h404, 32'h0000_1234);
      chk("R7", "pending set", 64'(irq_pend), 64'h0000_0000_AAAA_5555);
      chk("R7", "active set", 64'(irq_act), 64'h0000_1234_0000_0000);
      chk("R7", "enable untouched", 64'(irq_en), 64'h8000_0001_0000_00C3);
      wr32(12'h380, 32'hFFFF_0000);
      chk("R7", "pending drop", 64'(irq_pend), 64'h0000_0000_0000_5555);
      wr32(12'h484, 32'h0000_0204);
      chk("R7", "active drop", 64'(irq_act), 64'h0000_1030_0000_0000);
      rd32(12'h404);
      chk("R7", "active readback", 64'(r_data), 64'h1030);
   endtask

   task automatic t_raz;
      wr32(12'h100, 32'hFFFF_FFFF);
      rd32(12'h100);
      chk("R8", "group reads zero", 64'(r_data), 64'h0);
      wr32(12'h208, 32'hFFFF_FFFF);
      chk("R8", "word beyond range ignored", 64'(irq_en), 64'h8000_0001_0000_00C3);
      chk("R8", "no upd", 64'(r_upd), 64'h0);
      rd32(12'h208);
      chk("R8", "word beyond range reads zero", 64'(r_data), 64'h0);
      rd32(12'hF00);
      chk("R8", "unmapped reads zero", 64'(r_data), 64'h0);
   endtask

   task automatic t_prio_cfg;
      wr32(12'h600, 32'h1122_3344);
      chk("R12", "no upd on priority", 64'(r_upd), 64'h0);
      wr32(12'h63C, 32'hDEAD_BEEF);
      rd32(12'h600);
      chk("R9", "priority word 0", 64'(r_data), 64'h1122_3344);
      rd32(12'h63C);
      chk("R9", "priority last word", 64'(r_data), 64'hDEAD_BEEF);
      wr32(12'h500, 32'hA5A5_0F0F);
      wr32(12'h50C, 32'h0000_0001);
      rd32(12'h500);
      chk("R10", "config word 0", 64'(r_data), 64'hA5A5_0F0F);
      rd32(12'h50C);
      chk("R10", "config last word", 64'(r_data), 64'h1);
      rd32(12'h510);
      chk("R10", "past config window", 64'(r_data), 64'h0);
   endtask

   task automatic t_abort;
      acc(1'b1, 12'h200, 4'd8, 32'hFFFF_FFFF);
      chk("R11", "abort on wide write", 64'(r_abort), 64'h1);
      chk("R11", "state kept", 64'(irq_en), 64'h8000_0001_0000_00C3);
      chk("R11", "no upd", 64'(r_upd), 64'h0);
      acc(1'b0, 12'h008, 4'd8, 32'h0);
      chk("R11", "abort on wide read", 64'(r_abort), 64'h1);
      chk("R11", "abort data zero", 64'(r_data), 64'h0);
      rd32(12'h008);
      chk("R11", "word access not aborted", 64'(r_abort), 64'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_timing();
      t_ctrl();
      t_type_ident();
      t_enable();
      t_pend_act();
      t_raz();
      t_prio_cfg();
      t_abort();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule